// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link. A client places one command on a valid/ready request port. There are four commands: read a run of words from a start address, write one word, allow programming, or forbid programming. The controller serialises a start bit, an opcode and an address field. For a write it also serialises sixteen data bits. It runs a divided serial clock while the device is selected and drives its data output while that clock is low. On a read it discards the leading dummy bit and hands each complete word back on a one-cycle strobe.

After a write the controller releases the select line and holds it low for the minimum deselect time. It then selects the device again and watches the returned data line until the device reports ready. If ready never comes within a parameterised number of cycles, the controller sets a timeout flag and returns to idle. One command is in flight at a time. The request port stays busy from the start of a frame until the closing deselect interval has run out.

Top module: `uwire_eeprom_host`

## Requirements
- R1: Every frame starts with a 1 bit, then a 2-bit opcode, then ADDR_W address bits, each sent most significant bit first. The opcode is 10 for read, 01 for write and 00 for the enable and disable commands. Command codes on `req_cmd` are 0 = read, 1 = write, 2 = enable programming, 3 = disable programming.
- R2: The enable command sends address bits with the top two set to 11 and the rest 0. The disable command sends an all-zero address field. Neither frame carries data bits.
- R3: A write frame appends the 16 bits of `req_wdata`, most significant first, after the address. Select drops at the serial clock fall that follows the rising edge on the last data bit.
- R4: A read of `req_count`+1 words runs as one continuous frame. The first bit returned after the address is dropped. Each following 16 bits form one word, first bit received being the MSB, and each word is reported with a one-cycle `rd_valid` pulse. Successive words come from successive device addresses, and the device's wrap from its top address back to 0 is passed through unchanged.
- R5: `ee_clk` is low whenever select is low. While running, it toggles every HALF_DIV system clocks, and its first rise comes HALF_DIV clocks after select rises. `ee_mosi` changes only while `ee_clk` is low, so it is stable at every rising edge.
- R6: Select stays low for at least CS_LOW_CYC system clocks before it rises again. This covers the interval between frames and the interval before a ready poll.
- R7: After a write frame and its deselect interval, select rises again with the serial clock stopped. `ee_miso` is then checked every cycle. A 1 ends the poll: select drops, the deselect interval runs, and the port returns to idle without a timeout.
- R8: If `ee_miso` stays 0 for POLL_LIMIT poll cycles, `wr_timeout` is set and select drops. The port returns to idle after the deselect interval. The flag stays set until the next command is accepted.
- R9: `req_ready` is high only when idle with select low. An accepted command drops it on the next cycle. After reset, select, serial clock, data out and `wr_timeout` are all 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Controller can accept a command |
| req_cmd | input | 2 | 0 read, 1 write, 2 enable, 3 disable |
| req_addr | input | ADDR_W | Word address (start address for reads) |
| req_wdata | input | DATA_W | Word to write |
| req_count | input | CNT_W | Number of read words minus one |
| rd_valid | output | 1 | One-cycle strobe with each read word |
| rd_data | output | DATA_W | Read word |
| wr_timeout | output | 1 | Last write never reported ready |
| ee_sel | output | 1 | Device select, active high |
| ee_clk | output | 1 | Serial clock to the device |
| ee_mosi | output | 1 | Serial data to the device |
| ee_miso | input | 1 | Serial data and ready status from the device |

## Verification
The bench includes a behavioural EEPROM that decodes each frame on the serial clock's rising edges. It streams read data with a leading dummy zero and reports busy for a set number of cycles after a programmed write. Single-word reads after writes separate correct bit order and data alignment from off-by-one dummy handling. A multi-word read across the top address shows that the frame keeps clocking through the wrap. Writes tried while programming is disabled, and after re-disabling, show that the enable and disable address fields are formed correctly. A short busy time against one longer than the poll limit separates a normal ready poll from the timeout path and the clearing of the flag.

// File: rtl/uwh_pkg.sv
// Shared types for the serial EEPROM host controller.
// Assumes: command codes are fixed by the request port definition.
package uwh_pkg;
    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_WREN  = 2'd2,
        CMD_WRDIS = 2'd3
    } uwh_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_GAP,
        ST_POLL
    } uwh_state_e;
endpackage

// File: rtl/uwh_sclk_gen.sv
// Serial clock divider. While run is high the output toggles every
// HALF_DIV system clocks, starting low. rise_p/fall_p mark the cycle at
// whose end the output goes high/low.
// Assumes: HALF_DIV >= 1; run drops at or after a falling strobe.
module uwh_sclk_gen #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_p,
    output logic fall_p
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick   = run && (cnt == CW'(HALF_DIV - 1));
    assign rise_p = tick && !sclk;
    assign fall_p = tick && sclk;

    // Count system clocks and toggle the serial clock at each half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);  // R5
endmodule

// File: rtl/uwh_frame_fmt.sv
// Builds the outgoing frame, left-justified: start bit, opcode, address
// field, then data for writes. Also returns the number of bits to send.
// Assumes: AW >= 2 so the enable/disable selector bits fit.
module uwh_frame_fmt
    import uwh_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  uwh_cmd_e                        cmd,
    input  logic [AW-1:0]                   addr,
    input  logic [DW-1:0]                   wdata,
    output logic [3+AW+DW-1:0]              frame,
    output logic [$clog2(3+AW+DW+1)-1:0]    nbits
);
    localparam int NBW = $clog2(3 + AW + DW + 1);

    logic [1:0]    op;
    logic [AW-1:0] afield;
    logic [DW-1:0] dfield;

    // Choose opcode, address field and length for each command.
    always_comb begin
        afield = '0;
        dfield = '0;
        op     = 2'b00;
        nbits  = NBW'(3 + AW);
        case (cmd)
            CMD_READ: begin
                op     = 2'b10;
                afield = addr;
            end
            CMD_WRITE: begin
                op     = 2'b01;
                afield = addr;
                dfield = wdata;
                nbits  = NBW'(3 + AW + DW);
            end
            CMD_WREN: begin
                afield[AW-1 -: 2] = 2'b11;
            end
            default: begin
                afield = '0;
            end
        endcase
        frame = {1'b1, op, afield, dfield};
    end
endmodule

// File: rtl/uwh_rx_deser.sv
// Collects serial read data. The first sample after clr is dropped; each
// following DW samples form one word, MSB first, issued with a strobe.
// Assumes: smp and clr are never high together.
module uwh_rx_deser #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          smp,
    input  logic          bit_in,
    output logic          word_valid,
    output logic [DW-1:0] word
);
    localparam int CW = $clog2(DW);

    logic          skip;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;

    // Drop the dummy bit, shift the rest and emit each full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip       <= 1'b1;
            cnt        <= '0;
            sh         <= '0;
            word       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (clr) begin
                skip <= 1'b1;
                cnt  <= '0;
            end else if (smp) begin
                if (skip) begin
                    skip <= 1'b0;
                end else begin
                    sh <= {sh[DW-2:0], bit_in};
                    if (cnt == CW'(DW - 1)) begin
                        cnt        <= '0;
                        word       <= {sh[DW-2:0], bit_in};
                        word_valid <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);  // R4
endmodule

// File: rtl/uwire_eeprom_host.sv
// Host controller for a three-wire serial EEPROM. Accepts one command at a
// time, sends the frame, gathers read words, enforces the deselect time
// and polls ready after writes, with a poll timeout.
// Assumes: CS_LOW_CYC >= 1, POLL_LIMIT >= 1, HALF_DIV >= 1, ADDR_W >= 2.
module uwire_eeprom_host
    import uwh_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 4,
    parameter int HALF_DIV   = 50,
    parameter int CS_LOW_CYC = 25,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  req_count,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_timeout,
    output logic              ee_sel,
    output logic              ee_clk,
    output logic              ee_mosi,
    input  logic              ee_miso
);
    localparam int FW  = 3 + ADDR_W + DATA_W;
    localparam int NBW = $clog2(FW + 1);
    localparam int RXW = $clog2(1 + DATA_W * (2 ** CNT_W) + 1);
    localparam int GW  = $clog2(CS_LOW_CYC + 1);
    localparam int PW  = $clog2(POLL_LIMIT + 1);

    uwh_state_e     state;
    logic [FW-1:0]  frame_w, sh_q;
    logic [NBW-1:0] nbits_w, tx_left;
    logic [RXW-1:0] rx_left;
    logic [GW-1:0]  gap_cnt;
    logic [PW-1:0]  poll_cnt;
    logic           poll_next;
    logic           run, rise_p, fall_p, smp_w, clr_w;

    assign req_ready = (state == ST_IDLE);
    assign run       = (state == ST_SHIFT);
    assign clr_w     = req_valid && req_ready;
    assign smp_w     = run && fall_p && (tx_left == '0) && (rx_left != '0);

    uwh_frame_fmt #(.AW(ADDR_W), .DW(DATA_W)) u_fmt (
        .cmd   (uwh_cmd_e'(req_cmd)),
        .addr  (req_addr),
        .wdata (req_wdata),
        .frame (frame_w),
        .nbits (nbits_w)
    );

    uwh_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .sclk   (ee_clk),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    uwh_rx_deser #(.DW(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_w),
        .smp        (smp_w),
        .bit_in     (ee_miso),
        .word_valid (rd_valid),
        .word       (rd_data)
    );

    // Command sequencer: frame shifting, deselect interval and ready poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ee_sel     <= 1'b0;
            ee_mosi    <= 1'b0;
            wr_timeout <= 1'b0;
            sh_q       <= '0;
            tx_left    <= '0;
            rx_left    <= '0;
            gap_cnt    <= '0;
            poll_cnt   <= '0;
            poll_next  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        sh_q       <= frame_w;
                        ee_mosi    <= frame_w[FW-1];
                        tx_left    <= nbits_w;
                        rx_left    <= (req_cmd == CMD_READ) ?
                            RXW'(1) + RXW'(DATA_W) * (RXW'(req_count) + RXW'(1)) : '0;
                        poll_next  <= (req_cmd == CMD_WRITE);
                        wr_timeout <= 1'b0;
                        ee_sel     <= 1'b1;
                        state      <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (rise_p && tx_left != '0) tx_left <= tx_left - 1'b1;
                    if (fall_p) begin
                        if (tx_left != '0) begin
                            sh_q    <= sh_q << 1;
                            ee_mosi <= sh_q[FW-2];
                        end else begin
                            ee_mosi <= 1'b0;
                            if (rx_left > RXW'(1)) begin
                                rx_left <= rx_left - 1'b1;
                            end else begin
                                rx_left <= '0;
                                ee_sel  <= 1'b0;
                                gap_cnt <= '0;
                                state   <= ST_GAP;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GW'(CS_LOW_CYC - 1)) begin
                        if (poll_next) begin
                            poll_next <= 1'b0;
                            poll_cnt  <= '0;
                            ee_sel    <= 1'b1;
                            state     <= ST_POLL;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                default: begin
                    if (ee_miso) begin
                        ee_sel  <= 1'b0;
                        gap_cnt <= '0;
                        state   <= ST_GAP;
                    end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
                        wr_timeout <= 1'b1;
                        ee_sel     <= 1'b0;
                        gap_cnt    <= '0;
                        state      <= ST_GAP;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Checker: count consecutive deselected cycles, saturating.
    logic [GW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                          low_run <= GW'(CS_LOW_CYC);
        else if (ee_sel)                     low_run <= '0;
        else if (low_run != GW'(CS_LOW_CYC)) low_run <= low_run + 1'b1;
    end

    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sel) |-> (low_run >= GW'(CS_LOW_CYC)));  // R6
    AST_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_sel |-> !ee_clk);  // R5
    AST_MOSI_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_clk) |-> $stable(ee_mosi));  // R5
    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && ee_sel));  // R9
    AST_READY_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !ee_sel);  // R9
    AST_TIMEOUT_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_timeout) |-> (!ee_sel && !req_ready));  // R8
    AST_WORD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(ee_sel));  // R4
endmodule

// File: tb/uwire_eeprom_host_tb.sv
// Bench: behavioural serial EEPROM plus per-clock protocol monitor and
// expected-memory reference.
module uwire_eeprom_host_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DEPTH = 64;
    localparam int HALF  = 2;
    localparam int CSLOW = 5;
    localparam int PLIM  = 200;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [2:0] req_count = '0;
    logic rd_valid, wr_timeout, ee_sel, ee_clk, ee_mosi, ee_miso;
    logic [15:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    uwire_eeprom_host #(.ADDR_W(AW), .DATA_W(16), .CNT_W(3), .HALF_DIV(HALF),
        .CS_LOW_CYC(CSLOW), .POLL_LIMIT(PLIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_count(req_count), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_timeout(wr_timeout), .ee_sel(ee_sel), .ee_clk(ee_clk),
        .ee_mosi(ee_mosi), .ee_miso(ee_miso));

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural EEPROM ----------------
    logic [15:0] mem [DEPTH];
    logic [15:0] exp_mem [DEPTH];
    int busy_len = 10;
    int nb, rb, rd_a, wa, cur_op;
    logic [31:0] hdr;
    logic [15:0] wd;
    bit wpend, en;
    logic sk_p, cs_p, rd_mode, rd_bit, st_mode;
    int busy_cnt;
    int fq_op[$], fq_addr[$], fq_data[$];

    assign ee_miso = ee_sel ? (rd_mode ? rd_bit : (st_mode ? (busy_cnt == 0) : 1'b0)) : 1'b0;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i]     = 16'((i * 16'h0101) ^ 16'h5A3C);
            exp_mem[i] = mem[i];
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            nb = 0; rb = 0; wpend = 0; en = 0; hdr = '0; cur_op = 0;
            sk_p <= 1'b0; cs_p <= 1'b0; rd_mode <= 1'b0; rd_bit <= 1'b0;
            st_mode <= 1'b0; busy_cnt <= 0;
        end else begin
            sk_p <= ee_clk;
            cs_p <= ee_sel;
            if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (cs_p && !ee_sel) begin
                rd_mode <= 1'b0;
                if (wpend) begin
                    wpend = 0;
                    if (en) begin mem[wa] = wd; busy_cnt <= busy_len; end
                    st_mode <= 1'b1;
                end
            end
            if (!ee_sel) nb = 0;
            else if (ee_clk && !sk_p) begin
                if (rd_mode) begin
                    rd_bit <= mem[rd_a][15-rb];
                    rb++;
                    if (rb == 16) begin rb = 0; rd_a = (rd_a + 1) % DEPTH; end
                end else if (nb == 0) begin
                    if (ee_mosi) begin nb = 1; hdr = 32'd1; st_mode <= 1'b0; end
                end else begin
                    hdr = {hdr[30:0], ee_mosi};
                    nb++;
                    if (nb == 3 + AW) begin
                        cur_op = int'(hdr[AW+1:AW]);
                        fq_op.push_back(cur_op);
                        fq_addr.push_back(int'(hdr[AW-1:0]));
                        if (cur_op == 2) begin
                            rd_mode <= 1'b1; rd_bit <= 1'b0;
                            rd_a = int'(hdr[AW-1:0]); rb = 0;
                        end else if (cur_op == 1) begin
                            wa = int'(hdr[AW-1:0]);
                        end else if (cur_op == 0) begin
                            if (hdr[AW-1:AW-2] == 2'b11) en = 1;
                            else if (hdr[AW-1:AW-2] == 2'b00) en = 0;
                        end
                    end
                    if (nb == 3 + AW + 16 && cur_op == 1) begin
                        wd = hdr[15:0]; wpend = 1;
                        fq_data.push_back(int'(hdr[15:0]));
                    end
                end
            end
        end
    end

    // ---------------- per-clock monitor ----------------
    int cyc = 0, last_ev = 0, cs_fall = -1000;
    bit seen_cs = 1'b0;
    logic m_sk = 1'b0, m_cs = 1'b0, m_do = 1'b0;
    logic [15:0] got_q[$];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(!(ee_clk && !ee_sel), "R5 clock while deselected", ee_clk, 0);
            chk(!(req_ready && ee_sel), "R9 ready while selected", req_ready, 0);
            chk(!(m_sk && ee_clk && ee_mosi != m_do), "R5 data moved with clock high", ee_mosi, m_do);
            if (ee_sel && !m_cs) begin
                if (seen_cs) chk(cyc - cs_fall >= CSLOW, "R6 deselect time", cyc - cs_fall, CSLOW);
                seen_cs = 1'b1;
                last_ev = cyc;
            end
            if (!ee_sel && m_cs) cs_fall = cyc;
            if (m_cs && ee_clk != m_sk) begin
                chk(cyc - last_ev == HALF, "R5 half period", cyc - last_ev, HALF);
                last_ev = cyc;
            end
            if (rd_valid) got_q.push_back(rd_data);
        end
        m_sk = ee_clk; m_cs = ee_sel; m_do = ee_mosi;
    end

    // ---------------- stimulus ----------------
    task automatic run_cmd(input logic [1:0] c, input int a, input logic [15:0] d,
                           input int nwords, output int dur);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_addr = AW'(a); req_wdata = d;
        req_count = 3'(nwords - 1);
        @(negedge clk);
        req_valid = 1'b0;
        dur = 1;
        while (!req_ready) begin @(negedge clk); dur++; end
    endtask

    task automatic chk_frame(input int op, input int a, input string req);
        int o, ad;
        if (fq_op.size() == 0) begin chk(0, req, -1, op); return; end
        o = fq_op.pop_front(); ad = fq_addr.pop_front();
        chk(o == op, {req, " opcode"}, o, op);
        chk(ad == a, {req, " address"}, ad, a);
    endtask

    task automatic do_write(input int a, input logic [15:0] d, input bit enabled,
                            output int dur);
        int dv;
        run_cmd(2'd1, a, d, 1, dur);
        chk_frame(1, a, "R1 write frame");
        dv = (fq_data.size() != 0) ? fq_data.pop_front() : -1;
        chk(dv == int'(d), "R3 write data bits", dv, int'(d));
        if (enabled) exp_mem[a] = d;
    endtask

    task automatic do_read(input int a, input int n);
        int dur, e;
        got_q.delete();
        run_cmd(2'd0, a, 16'h0, n, dur);
        chk_frame(2, a, "R1 read frame");
        chk(got_q.size() == n, "R4 word count", got_q.size(), n);
        for (int k = 0; k < n; k++) begin
            e = int'(exp_mem[(a + k) % DEPTH]);
            if (k < got_q.size()) chk(int'(got_q[k]) == e, "R4 read word", int'(got_q[k]), e);
        end
    endtask

    initial begin
        int dur;
        repeat (4) @(negedge clk);
        chk(!ee_sel && !ee_clk && !ee_mosi && !wr_timeout && req_ready,
            "R9 reset state", {ee_sel, ee_clk, ee_mosi, wr_timeout, req_ready}, 1);
        rst_n = 1'b1;

        // Write while programming disabled: no change.
        do_write(5, 16'hA5A5, 1'b0, dur);
        chk(!wr_timeout, "R7 disabled write ready", wr_timeout, 0);
        do_read(5, 1);

        // Enable programming.
        run_cmd(2'd2, 9, 16'hFFFF, 1, dur);
        chk_frame(0, 3 << (AW - 2), "R2 enable frame");

        // Normal write with busy poll.
        busy_len = 30;
        do_write(5, 16'hA5A5, 1'b1, dur);
        chk(dur >= 30, "R7 poll waited for ready", dur, 30);
        chk(!wr_timeout, "R7 no timeout", wr_timeout, 0);
        do_read(5, 1);

        // Multi-word read across the top address.
        busy_len = 10;
        do_write(63, 16'h1234, 1'b1, dur);
        do_read(62, 4);
        do_read(10, 8);

        // Disable programming, write must not land.
        run_cmd(2'd3, 21, 16'h0, 1, dur);
        chk_frame(0, 0, "R2 disable frame");
        do_write(0, 16'hFFFF, 1'b0, dur);
        do_read(0, 1);

        // Timeout path.
        run_cmd(2'd2, 0, 16'h0, 1, dur);
        chk_frame(0, 3 << (AW - 2), "R2 enable frame");
        busy_len = 1000;
        do_write(7, 16'h0F0F, 1'b1, dur);
        chk(wr_timeout, "R8 timeout flag set", wr_timeout, 1);
        chk(dur >= PLIM && dur < 1000, "R8 timeout duration", dur, PLIM);
        repeat (1000) @(negedge clk);
        chk(wr_timeout, "R8 flag holds while idle", wr_timeout, 1);
        do_read(7, 1);
        chk(!wr_timeout, "R8 flag cleared by next command", wr_timeout, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++; miscompares++;
            $display("FAIL R9 watchdog expired actual=0 expected=1");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule